// File: doc/BRIEF.md
# PTP Time-of-Day Clock with Paged Register Access

This block keeps a running time of day as a 32-bit nanoseconds field and a 32-bit seconds field. While enabled, it adds 8 ns on every clock cycle, so it assumes a 125 MHz clock. When the nanoseconds field would reach one billion, it wraps and the seconds field counts up by one.

Software reaches the block through a 16-bit register bus with a 5-bit address. Addresses 0x00 to 0x13 are fixed. Addresses 0x14 to 0x1F are a window onto one of several pages, and a page-select register at 0x13 chooses which page the window shows. The time controls appear only on page 4. On that page, 0x14 is a control register and 0x15 is a single 16-bit data port. The 64-bit time passes through the data port as four words, ordered by internal pointers:

- **Setting the time:** write four words to the data port, then set the load command bit in the control register.
- **Reading the time:** set the capture command bit, then read four words from the data port.

Requests use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A read answers one cycle later with `rsp_valid`. The answer is held, with its data steady, until `rsp_ready` is seen high. While an answer is outstanding, `req_ready` stays low, so no new request of either kind is taken. A write produces no answer.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the nanoseconds and seconds outputs are 0, the clock is disabled, the page register reads 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Address 0x13 stores `req_wdata[2:0]` as the page number, whatever the current page is. A read of 0x13 returns the last page written in bits 2:0, with 0 in bits 15:3.
- R3: Addresses 0x14 and 0x15 act only while the page is 4. On any other page, reads of them return 0 and writes to them change nothing: enable, staged time and word pointer are all unaffected.
- R4: Control bit 2 is an enable level that holds until rewritten. A read of the control register returns the enable in bit 2 and 0 in every other bit, including the command bits.
- R5: Writes to the data port fill four staging words in this order: nanoseconds[15:0], nanoseconds[31:16], seconds[15:0], seconds[31:16]. A 2-bit write pointer orders the words and wraps after the fourth.
- R6: Writing control bit 4 as 1 loads the staged time into the clock on the edge that takes the write, and resets the write pointer to the first word. A load overrides that cycle's increment.
- R7: While enabled, the nanoseconds field grows by 8 on each clock edge. While disabled and not loading, both fields hold.
- R8: An increment that would reach 1,000,000,000 ns instead leaves (ns + 8 − 1,000,000,000) and adds 1 to the seconds field. Nanoseconds stays below 1,000,000,000 as long as the loaded values are below it.
- R9: Writing control bit 5 as 1 copies the whole 64-bit time, as it stood before that edge's update, into a snapshot, and resets the 2-bit read pointer. Later data-port reads return nanoseconds low, nanoseconds high, seconds low, seconds high, then wrap. The snapshot does not change as the clock runs.
- R10: A read answer stays valid with stable data while `rsp_ready` is 0, and `req_ready` stays 0 while an answer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read answer present |
| rsp_ready | input | 1 | Requester takes the answer |
| rsp_rdata | output | 16 | Read answer data |
| tod_ns | output | 32 | Running nanoseconds field |
| tod_sec | output | 32 | Running seconds field |
| tod_enabled | output | 1 | Clock enable level |

## Verification
The hardest case to reach is a capture taken while the clock runs across a seconds carry, where the lower seconds word also rolls into the upper word. The stimulus stages a time a few steps below one billion nanoseconds, with the seconds value at 0x0001FFFF, and loads and enables it in one write. It then follows the carry cycle by cycle, captures, and reads the four words while the clock keeps moving. Pointer resets are reached by loading after only part of a word sequence, and by capturing again midway through a read sequence. Back-pressure is reached by holding `rsp_ready` low while a second request waits.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned FIELD_W = 32;
  localparam int unsigned TOD_W  = 2 * FIELD_W;
  localparam int unsigned NUM_WORDS = TOD_W / BUS_W;
  localparam int unsigned PTR_W  = $clog2(NUM_WORDS);

  typedef struct packed {
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] ns;
  } tod_t;
endpackage

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_STEP = 8,
  parameter int unsigned NS_WRAP = 1000000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic load,
  input  tod_t load_val,
  output tod_t tod
);
  localparam logic [FIELD_W:0] STEP_X  = (FIELD_W+1)'(NS_STEP);
  localparam logic [FIELD_W:0] LIMIT_X = (FIELD_W+1)'(NS_WRAP);

  tod_t             tod_q;
  logic [FIELD_W:0] ns_sum;
  logic             wrap;

  assign ns_sum = {1'b0, tod_q.ns} + STEP_X;
  assign wrap   = (ns_sum >= LIMIT_X);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q <= '0;
    end else if (load) begin
      tod_q <= load_val;
    end else if (enable) begin
      if (wrap) begin
        tod_q.ns  <= FIELD_W'(ns_sum - LIMIT_X);
        tod_q.sec <= tod_q.sec + 1'b1;
      end else begin
        tod_q.ns  <= FIELD_W'(ns_sum);
      end
    end
  end

  assign tod = tod_q;
endmodule

// File: rtl/ptp_tod_dataport.sv
module ptp_tod_dataport
  import ptp_tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  input  logic             load,
  input  logic             cap,
  input  logic             rd_adv,
  input  tod_t             live,
  output tod_t             staged,
  output logic [BUS_W-1:0] rd_word
);
  logic [NUM_WORDS-1:0][BUS_W-1:0] stage_q;
  logic [NUM_WORDS-1:0][BUS_W-1:0] snap_q;
  logic [PTR_W-1:0]                wr_ptr_q;
  logic [PTR_W-1:0]                rd_ptr_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[w] <= '0;
      end else if (wr_en && (wr_ptr_q == PTR_W'(w))) begin
        stage_q[w] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
    end else if (load) begin
      wr_ptr_q <= '0;
    end else if (wr_en) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q   <= '0;
      rd_ptr_q <= '0;
    end else if (cap) begin
      snap_q   <= live;
      rd_ptr_q <= '0;
    end else if (rd_adv) begin
      rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign staged  = tod_t'(stage_q);
  assign rd_word = snap_q[rd_ptr_q];
endmodule

// File: rtl/ptp_tod_regbus.sv
module ptp_tod_regbus
  import ptp_tod_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 5'h13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h14,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h15,
  parameter int unsigned       PAGE_W    = 3,
  parameter int unsigned       TIME_PAGE = 4,
  parameter int unsigned       EN_BIT    = 2,
  parameter int unsigned       LOAD_BIT  = 4,
  parameter int unsigned       CAP_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic [BUS_W-1:0]  port_word,
  output logic              enable,
  output logic              load_pulse,
  output logic              cap_pulse,
  output logic              port_wr,
  output logic              port_rd
);
  logic [PAGE_W-1:0] page_q;
  logic              en_q;
  logic              rsp_valid_q;
  logic [BUS_W-1:0]  rsp_rdata_q;
  logic              accept, wr_acc, rd_acc;
  logic              on_time_page, hit_page, hit_ctrl, hit_data;
  logic [BUS_W-1:0]  rd_mux;

  assign req_ready    = !rsp_valid_q;
  assign accept       = req_valid && req_ready;
  assign wr_acc       = accept && req_write;
  assign rd_acc       = accept && !req_write;
  assign on_time_page = (page_q == PAGE_W'(TIME_PAGE));
  assign hit_page     = (req_addr == PAGE_ADDR);
  assign hit_ctrl     = on_time_page && (req_addr == CTRL_ADDR);
  assign hit_data     = on_time_page && (req_addr == DATA_ADDR);

  assign load_pulse = wr_acc && hit_ctrl && req_wdata[LOAD_BIT];
  assign cap_pulse  = wr_acc && hit_ctrl && req_wdata[CAP_BIT];
  assign port_wr    = wr_acc && hit_data;
  assign port_rd    = rd_acc && hit_data;

  always_comb begin
    rd_mux = '0;
    if (hit_page) begin
      rd_mux[PAGE_W-1:0] = page_q;
    end else if (hit_ctrl) begin
      rd_mux[EN_BIT] = en_q;
    end else if (hit_data) begin
      rd_mux = port_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_acc) begin
      if (hit_page) page_q <= req_wdata[PAGE_W-1:0];
      if (hit_ctrl) en_q   <= req_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= rd_mux;
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign enable    = en_q;
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_STEP   = 8,
  parameter int unsigned NS_WRAP   = 1000000000,
  parameter int unsigned TIME_PAGE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]   req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BUS_W-1:0]   rsp_rdata,
  output logic [FIELD_W-1:0] tod_ns,
  output logic [FIELD_W-1:0] tod_sec,
  output logic               tod_enabled
);
  logic             enable, load_pulse, cap_pulse, port_wr, port_rd;
  logic [BUS_W-1:0] port_word;
  tod_t             live_tod, staged_tod;

  ptp_tod_regbus #(.TIME_PAGE(TIME_PAGE)) regbus_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .port_word(port_word), .enable(enable), .load_pulse(load_pulse),
    .cap_pulse(cap_pulse), .port_wr(port_wr), .port_rd(port_rd)
  );

  ptp_tod_dataport dataport_i (
    .clk(clk), .rst_n(rst_n), .wr_en(port_wr), .wdata(req_wdata),
    .load(load_pulse), .cap(cap_pulse), .rd_adv(port_rd),
    .live(live_tod), .staged(staged_tod), .rd_word(port_word)
  );

  ptp_tod_counter #(.NS_STEP(NS_STEP), .NS_WRAP(NS_WRAP)) counter_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(load_pulse),
    .load_val(staged_tod), .tod(live_tod)
  );

  assign tod_ns      = live_tod.ns;
  assign tod_sec     = live_tod.sec;
  assign tod_enabled = enable;
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
#(
  parameter int unsigned NS_STEP = 8,
  parameter int unsigned NS_WRAP = 1000000000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] tod_ns,
  input logic [31:0] tod_sec,
  input logic        tod_enabled,
  input logic        load_pulse,
  input logic [63:0] staged,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata
);
  AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < 32'(NS_WRAP)); // R8
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tod_enabled && !load_pulse) |=> ($stable(tod_ns) && $stable(tod_sec))); // R7
  AST_STEP_OR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_enabled && !load_pulse) |=>
      ((tod_ns == $past(tod_ns) + 32'(NS_STEP)) || (tod_sec == $past(tod_sec) + 32'd1))); // R7
  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_enabled && !load_pulse && tod_ns >= 32'(NS_WRAP - NS_STEP)) |=>
      ((tod_sec == $past(tod_sec) + 32'd1) && (tod_ns < 32'(NS_STEP)))); // R8
  AST_LOAD_TAKES_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> ({tod_sec, tod_ns} == $past(staged))); // R6
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
endmodule

bind ptp_tod_clock ptp_tod_chk #(.NS_STEP(NS_STEP), .NS_WRAP(NS_WRAP)) chk_i (
  .clk(clk), .rst_n(rst_n), .tod_ns(tod_ns), .tod_sec(tod_sec),
  .tod_enabled(tod_enabled), .load_pulse(load_pulse), .staged(staged_tod),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata)
);

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb_top;
  localparam logic [4:0] A_PAGE = 5'h13;
  localparam logic [4:0] A_CTRL = 5'h14;
  localparam logic [4:0] A_DATA = 5'h15;
  localparam logic [31:0] WRAP  = 32'd1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, tod_enabled;
  logic [15:0] rsp_rdata;
  logic [31:0] tod_ns, tod_sec;

  int checks = 0, failures = 0;
  logic [31:0] pre_ns, pre_sec, e_ns, e_sec;
  logic [15:0] rd;

  always #5 clk = ~clk;

  ptp_tod_clock dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tod_ns(tod_ns), .tod_sec(tod_sec), .tod_enabled(tod_enabled)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    pre_ns = tod_ns; pre_sec = tod_sec;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 16'hDEAD;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic stage(input logic [31:0] ns, input logic [31:0] sec);
    bus_wr(A_DATA, ns[15:0]);  bus_wr(A_DATA, ns[31:16]);
    bus_wr(A_DATA, sec[15:0]); bus_wr(A_DATA, sec[31:16]);
  endtask

  task automatic step_exp();
    if ({1'b0, e_ns} + 33'd8 >= {1'b0, WRAP}) begin
      e_ns = e_ns + 32'd8 - WRAP; e_sec = e_sec + 32'd1;
    end else e_ns = e_ns + 32'd8;
  endtask

  task automatic read_snapshot(input logic [31:0] ns, input logic [31:0] sec);
    bus_rd(A_DATA, rd); chk("R9 ns_lo", 64'(rd), 64'(ns[15:0]));
    bus_rd(A_DATA, rd); chk("R9 ns_hi", 64'(rd), 64'(ns[31:16]));
    bus_rd(A_DATA, rd); chk("R9 sec_lo", 64'(rd), 64'(sec[15:0]));
    bus_rd(A_DATA, rd); chk("R9 sec_hi", 64'(rd), 64'(sec[31:16]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ns", 64'(tod_ns), 64'd0);
    chk("R1 sec", 64'(tod_sec), 64'd0);
    chk("R1 enabled", 64'(tod_enabled), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    bus_rd(A_PAGE, rd); chk("R1 page", 64'(rd), 64'd0);

    // R2 page sweep, upper bits written as ones
    for (int p = 0; p < 8; p++) begin
      bus_wr(A_PAGE, 16'hFFF8 | 16'(p));
      bus_rd(A_PAGE, rd); chk("R2 page readback", 64'(rd), 64'(p));
    end
    bus_rd(5'h00, rd); chk("R2 fixed reg", 64'(rd), 64'd0);

    // R3 time registers inert off the time page
    bus_wr(A_PAGE, 16'd2);
    bus_wr(A_CTRL, 16'h0014);
    chk("R3 enable ignored", 64'(tod_enabled), 64'd0);
    chk("R3 load ignored", {tod_sec, tod_ns}, 64'd0);
    bus_wr(A_DATA, 16'h1234); bus_wr(A_DATA, 16'h5678);
    bus_rd(A_CTRL, rd); chk("R3 ctrl reads 0", 64'(rd), 64'd0);
    bus_rd(A_DATA, rd); chk("R3 data reads 0", 64'(rd), 64'd0);

    // R5 R6 staging order and load while disabled
    bus_wr(A_PAGE, 16'd4);
    stage(32'd123456784, 32'h00ABCDEF);
    bus_wr(A_CTRL, 16'h0010);
    chk("R6 load ns", 64'(tod_ns), 64'd123456784);
    chk("R5 load sec", 64'(tod_sec), 64'h00ABCDEF);
    repeat (5) @(negedge clk);
    chk("R7 hold disabled", {tod_sec, tod_ns}, {32'h00ABCDEF, 32'd123456784});
    bus_rd(A_CTRL, rd); chk("R4 ctrl cmd bits read 0", 64'(rd), 64'd0);

    // R6 write pointer reset after a partial sequence
    bus_wr(A_DATA, 16'hAAA8); bus_wr(A_DATA, 16'h0BBB);
    bus_wr(A_CTRL, 16'h0010);
    chk("R6 partial load", {tod_sec, tod_ns}, {32'h00ABCDEF, 32'h0BBBAAA8});
    stage(32'd504, 32'd7);
    bus_wr(A_CTRL, 16'h0010);
    chk("R6 ptr reset load", {tod_sec, tod_ns}, {32'd7, 32'd504});

    // R7 R8 enable with load close to the seconds carry
    stage(WRAP - 32'd40, 32'h0001FFFF);
    bus_wr(A_CTRL, 16'h0014);
    e_ns = WRAP - 32'd40; e_sec = 32'h0001FFFF;
    chk("R6 load with enable", {tod_sec, tod_ns}, {e_sec, e_ns});
    chk("R4 enable level", 64'(tod_enabled), 64'd1);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      step_exp();
      chk("R8 run/wrap", {tod_sec, tod_ns}, {e_sec, e_ns});
    end
    bus_rd(A_CTRL, rd); chk("R4 ctrl readback", 64'(rd), 64'h0004);

    // R9 atomic capture while running
    bus_wr(A_CTRL, 16'h0024);
    e_ns = pre_ns; e_sec = pre_sec;
    chk("R4 still enabled", 64'(tod_enabled), 64'd1);
    read_snapshot(e_ns, e_sec);
    bus_rd(A_DATA, rd); chk("R9 pointer wraps", 64'(rd), 64'(e_ns[15:0]));
    bus_rd(A_DATA, rd);
    bus_wr(A_CTRL, 16'h0024);
    e_ns = pre_ns; e_sec = pre_sec;
    bus_rd(A_DATA, rd); chk("R9 recapture resets ptr", 64'(rd), 64'(e_ns[15:0]));

    // R10 back-pressure on the answer
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_DATA; rsp_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held valid", 64'(rsp_valid), 64'd1);
      chk("R10 held data", 64'(rsp_rdata), 64'(e_ns[31:16]));
      chk("R10 not ready", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next answer", {47'd0, rsp_valid, rsp_rdata}, {47'd0, 1'b1, e_sec[15:0]});
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 answer taken", 64'(rsp_valid), 64'd0);

    // R7 disable holds
    bus_wr(A_CTRL, 16'h0000);
    e_ns = tod_ns; e_sec = tod_sec;
    repeat (4) @(negedge clk);
    chk("R7 hold after disable", {tod_sec, tod_ns}, {e_sec, e_ns});
    chk("R4 disabled", 64'(tod_enabled), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule